// File: doc/BRIEF.md
# UART Data Register Buffering Unit

This block sits between a processor bus and the serial engines of a UART. One bus data address serves both directions. A bus write places a byte in a single-entry transmit holding buffer. A bus read returns the oldest byte of a two-entry receive queue and removes it from the queue. The block hands held bytes to the transmit shifter over a valid/ready handshake. It takes received bytes from the receive shifter as one-cycle strobes. Baud timing, serialisation, parity and interrupt vectoring live elsewhere.

Three controllers are built as state machines. The transmit holder has the states HOLD_EMPTY and HOLD_FULL. A write that is accepted moves it from HOLD_EMPTY to HOLD_FULL, and a handoff to the shifter moves it back. The receive queue has the states RXQ_EMPTY, RXQ_ONE and RXQ_TWO. A push moves it up one state, a pop moves it down one state, and a push together with a pop keeps the occupancy. Dropping the receive enable forces RXQ_EMPTY from any state. The transmit-complete flag has the states TXC_CLEAR and TXC_SET. A frame-done event while the holder is empty moves it to TXC_SET. An acknowledge or a write-one clear moves it back, unless a set event occurs in the same cycle.

A two-bit character-size select masks data in both directions. Its codes are 0 for 5 bits, 1 for 6 bits, 2 for 7 bits and 3 for 8 bits.

Top module: `uart_databuf`

## Requirements
- R1: A bus write while `flag_dre` is 1 stores the masked byte. From the next cycle `flag_dre` is 0 and `tx_data` shows the byte; `tx_valid` is 1 while `tx_en` is 1.
- R2: A bus write while `flag_dre` is 0 is ignored, and `tx_data` keeps the earlier byte.
- R3: `tx_valid` is 0 while `tx_en` is 0. A cycle with both `tx_valid` and `tx_ready` high empties the holder, so `flag_dre` is 1 from the next cycle.
- R4: A `tx_frame_done` pulse while `flag_dre` is 1 sets `flag_txc` from the next cycle. While `flag_dre` is 0 the pulse leaves `flag_txc` at 0.
- R5: `flag_txc` clears after a `txc_ack` pulse or a `txc_clr` pulse. If a set event comes in the same cycle, the set wins and the flag stays 1.
- R6: After reset `flag_dre` is 1, `flag_rxc`, `flag_txc`, `flag_ovr` and `tx_valid` are 0, and `bus_rdata` is 0.
- R7: The receive queue holds two bytes in arrival order. `bus_rdata` shows the oldest byte. A cycle with `bus_rd` high removes that byte. `flag_rxc` is 1 exactly when the queue is not empty.
- R8: A strobe that arrives while the queue holds two bytes, with no read in the same cycle, is dropped and sets `flag_ovr`. The next read clears `flag_ovr`. A strobe that coincides with a read of a full queue is accepted.
- R9: While `rx_en` is 0 the queue is emptied and strobes are ignored. `flag_rxc` and `flag_ovr` read 0 from the cycle after `rx_en` falls.
- R10: The character-size code selects the width: 0 is 5 bits, 1 is 6 bits, 2 is 7 bits and 3 is 8 bits. Bits above the width are cleared in written bytes before they reach `tx_data`. They are also cleared in received bytes before they reach `bus_rdata`.
- R11: A read of an empty queue returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_sel | input | 2 | Character size code (0:5, 1:6, 2:7, 3:8 bits) |
| bus_wr | input | 1 | Write strobe for the data address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe for the data address (pops the queue) |
| bus_rdata | output | 8 | Oldest received byte, 0 when empty |
| tx_en | input | 1 | Transmitter enable |
| tx_valid | output | 1 | Held byte offered to the shifter |
| tx_ready | input | 1 | Shifter is empty and can take a byte |
| tx_data | output | 8 | Byte offered to the shifter |
| tx_frame_done | input | 1 | Pulse when the shifter has sent a whole frame |
| txc_ack | input | 1 | Transmit-complete interrupt acknowledge pulse |
| txc_clr | input | 1 | Write-one clear of the transmit-complete flag |
| rx_en | input | 1 | Receiver enable |
| rx_strobe | input | 1 | One-cycle pulse carrying a received byte |
| rx_byte | input | 8 | Received byte |
| flag_rxc | output | 1 | Receive complete: unread data present |
| flag_txc | output | 1 | Transmit complete (sticky) |
| flag_dre | output | 1 | Data register empty |
| flag_ovr | output | 1 | Receive overrun |

## Verification
The bench writes into a full holder and checks that the first byte survives. A design that lets the write through would send the wrong byte. A third strobe into a full queue is checked for both outcomes. Without a read it must be dropped and flag overrun; a design that overwrote a slot would corrupt the byte order. With a coinciding read it must be accepted; a design that treats it as full would lose good data. The set-versus-clear collision on the transmit-complete flag is checked, because a design that gives the clear priority would lose a completion event. The bench also checks that a flush on receiver disable removes queued bytes and the overrun state, and that each size code masks exactly the bits above the chosen width.

// File: rtl/uart_databuf_pkg.sv
package uart_databuf_pkg;

    typedef enum logic {
        HOLD_EMPTY,
        HOLD_FULL
    } hold_state_e;

    typedef enum logic [1:0] {
        RXQ_EMPTY,
        RXQ_ONE,
        RXQ_TWO
    } rxq_state_e;

    typedef enum logic {
        TXC_CLEAR,
        TXC_SET
    } txc_state_e;

endpackage

// File: rtl/udb_char_mask.sv
module udb_char_mask #(
    parameter int DATA_W   = 8,
    parameter int SEL_W    = 2,
    parameter int MIN_CHAR = 5
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] dout
);

    // Bit b survives when the chosen width (MIN_CHAR + sel) exceeds b.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b < MIN_CHAR) begin : g_always
            assign dout[b] = din[b];
        end else begin : g_sized
            assign dout[b] = din[b] & (int'(sel) > (b - MIN_CHAR));
        end
    end

endmodule

// File: rtl/udb_tx_hold.sv
module udb_tx_hold
    import uart_databuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_en,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              empty
);

    hold_state_e       state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              load;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            HOLD_EMPTY: begin
                if (wr) begin
                    state_d = HOLD_FULL;
                    load    = 1'b1;
                end
            end
            HOLD_FULL: begin
                if (tx_en && tx_ready) begin
                    state_d = HOLD_EMPTY;
                end
            end
            default: state_d = HOLD_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HOLD_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= wdata;
        end
    end

    always_comb begin
        tx_valid = 1'b0;
        empty    = 1'b0;
        unique case (state_q)
            HOLD_EMPTY: empty    = 1'b1;
            HOLD_FULL:  tx_valid = tx_en;
            default:    empty    = 1'b1;
        endcase
    end

    assign tx_data = data_q;

    assert_write_fills_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && wr) |=> (!empty && tx_data == $past(wdata)));

    assert_drop_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && wr) |=> $stable(data_q));

    assert_handoff_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> empty);

endmodule

// File: rtl/udb_rx_fifo.sv
module udb_rx_fifo
    import uart_databuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              nonempty,
    output logic              overrun
);

    rxq_state_e        state_q, state_d;
    logic [DATA_W-1:0] slot0_q, slot1_q;
    logic              ovr_q;
    logic              push_ok, pop_ok;
    logic              ld0, ld1, shift, drop;

    assign push_ok = enable && push;
    assign pop_ok  = enable && pop;

    always_comb begin
        state_d = state_q;
        ld0     = 1'b0;
        ld1     = 1'b0;
        shift   = 1'b0;
        drop    = 1'b0;
        if (!enable) begin
            state_d = RXQ_EMPTY;
        end else begin
            unique case (state_q)
                RXQ_EMPTY: begin
                    if (push_ok) begin
                        state_d = RXQ_ONE;
                        ld0     = 1'b1;
                    end
                end
                RXQ_ONE: begin
                    if (push_ok && pop_ok) begin
                        ld0 = 1'b1;
                    end else if (push_ok) begin
                        state_d = RXQ_TWO;
                        ld1     = 1'b1;
                    end else if (pop_ok) begin
                        state_d = RXQ_EMPTY;
                    end
                end
                RXQ_TWO: begin
                    if (push_ok && pop_ok) begin
                        shift = 1'b1;
                        ld1   = 1'b1;
                    end else if (pop_ok) begin
                        shift   = 1'b1;
                        state_d = RXQ_ONE;
                    end else if (push_ok) begin
                        drop = 1'b1;
                    end
                end
                default: state_d = RXQ_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RXQ_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot0_q <= '0;
            slot1_q <= '0;
        end else begin
            if (shift) begin
                slot0_q <= slot1_q;
            end else if (ld0) begin
                slot0_q <= push_data;
            end
            if (ld1) begin
                slot1_q <= push_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (!enable) begin
            ovr_q <= 1'b0;
        end else if (drop) begin
            ovr_q <= 1'b1;
        end else if (pop_ok) begin
            ovr_q <= 1'b0;
        end
    end

    always_comb begin
        head     = '0;
        nonempty = 1'b0;
        unique case (state_q)
            RXQ_EMPTY: nonempty = 1'b0;
            RXQ_ONE, RXQ_TWO: begin
                head     = slot0_q;
                nonempty = 1'b1;
            end
            default: nonempty = 1'b0;
        endcase
    end

    assign overrun = ovr_q;

    assert_order_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == RXQ_TWO && pop && !push) |=> (head == $past(slot1_q)));

    assert_drop_sets_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && push && !pop && state_q == RXQ_TWO)
        |=> (overrun && state_q == RXQ_TWO && $stable(slot1_q)));

    assert_read_clears_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pop) |=> !overrun);

    assert_flush_on_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!nonempty && !overrun));

endmodule

// File: rtl/udb_txc_flag.sv
module udb_txc_flag
    import uart_databuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done,
    input  logic hold_empty,
    input  logic ack,
    input  logic clr,
    output logic flag
);

    txc_state_e state_q, state_d;
    logic       set_evt;

    assign set_evt = frame_done && hold_empty;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXC_CLEAR: if (set_evt) state_d = TXC_SET;
            TXC_SET:   if ((ack || clr) && !set_evt) state_d = TXC_CLEAR;
            default:   state_d = TXC_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TXC_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            TXC_SET: flag = 1'b1;
            default: flag = 1'b0;
        endcase
    end

    assert_set_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && hold_empty) |=> flag);

    assert_no_set_while_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !hold_empty) |=> !flag);

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && (ack || clr) && !(frame_done && hold_empty)) |=> !flag);

endmodule

// File: rtl/uart_databuf.sv
module uart_databuf #(
    parameter int DATA_W   = 8,
    parameter int SEL_W    = 2,
    parameter int MIN_CHAR = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  char_sel,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_en,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_frame_done,
    input  logic              txc_ack,
    input  logic              txc_clr,
    input  logic              rx_en,
    input  logic              rx_strobe,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              flag_rxc,
    output logic              flag_txc,
    output logic              flag_dre,
    output logic              flag_ovr
);

    logic [DATA_W-1:0] wdata_sized;
    logic [DATA_W-1:0] rx_sized;
    logic              hold_empty;

    udb_char_mask #(.DATA_W(DATA_W), .SEL_W(SEL_W), .MIN_CHAR(MIN_CHAR)) u_tx_mask (
        .din  (bus_wdata),
        .sel  (char_sel),
        .dout (wdata_sized)
    );

    udb_char_mask #(.DATA_W(DATA_W), .SEL_W(SEL_W), .MIN_CHAR(MIN_CHAR)) u_rx_mask (
        .din  (rx_byte),
        .sel  (char_sel),
        .dout (rx_sized)
    );

    udb_tx_hold #(.DATA_W(DATA_W)) u_tx_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .wdata    (wdata_sized),
        .tx_en    (tx_en),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .empty    (hold_empty)
    );

    udb_rx_fifo #(.DATA_W(DATA_W)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (rx_en),
        .push      (rx_strobe),
        .push_data (rx_sized),
        .pop       (bus_rd),
        .head      (bus_rdata),
        .nonempty  (flag_rxc),
        .overrun   (flag_ovr)
    );

    udb_txc_flag u_txc_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (tx_frame_done),
        .hold_empty (hold_empty),
        .ack        (txc_ack),
        .clr        (txc_clr),
        .flag       (flag_txc)
    );

    assign flag_dre = hold_empty;

    assert_empty_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_rxc |-> (bus_rdata == '0));

    assert_valid_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !flag_dre) |=> !flag_dre || $past(tx_en));

endmodule

// File: tb/tb_uart_databuf.sv
module tb_uart_databuf;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] char_sel;
    logic       bus_wr, bus_rd;
    logic [7:0] bus_wdata, bus_rdata;
    logic       tx_en, tx_valid, tx_ready;
    logic [7:0] tx_data;
    logic       tx_frame_done, txc_ack, txc_clr;
    logic       rx_en, rx_strobe;
    logic [7:0] rx_byte;
    logic       flag_rxc, flag_txc, flag_dre, flag_ovr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    uart_databuf dut (
        .clk(clk), .rst_n(rst_n), .char_sel(char_sel),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tx_en(tx_en), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_frame_done(tx_frame_done), .txc_ack(txc_ack), .txc_clr(txc_clr),
        .rx_en(rx_en), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
        .flag_rxc(flag_rxc), .flag_txc(flag_txc), .flag_dre(flag_dre), .flag_ovr(flag_ovr)
    );

    // {size code, tx in, tx expected, rx in, rx expected}
    localparam int NVEC = 6;
    localparam logic [33:0] VEC [NVEC] = '{
        {2'd3, 8'hA5, 8'hA5, 8'h3C, 8'h3C},
        {2'd2, 8'hFF, 8'h7F, 8'h80, 8'h00},
        {2'd1, 8'hC7, 8'h07, 8'h5A, 8'h1A},
        {2'd0, 8'hF3, 8'h13, 8'h2E, 8'h0E},
        {2'd0, 8'h1F, 8'h1F, 8'hE0, 8'h00},
        {2'd2, 8'h81, 8'h01, 8'h7F, 8'h7F}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; tx_ready = 0; tx_frame_done = 0;
        txc_ack = 0; txc_clr = 0; rx_strobe = 0;
    endtask

    task automatic bus_write(input logic [7:0] d);
        bus_wdata = d; bus_wr = 1; step();
    endtask

    task automatic push_rx(input logic [7:0] d);
        rx_byte = d; rx_strobe = 1; step();
    endtask

    task automatic bus_read();
        bus_rd = 1; step();
    endtask

    task automatic handoff();
        tx_ready = 1; step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; char_sel = 2'd3; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
        tx_en = 1; tx_ready = 0; tx_frame_done = 0; txc_ack = 0; txc_clr = 0;
        rx_en = 1; rx_strobe = 0; rx_byte = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R6 reset state
        chk("R6 dre", {7'd0, flag_dre}, 8'd1);
        chk("R6 rxc", {7'd0, flag_rxc}, 8'd0);
        chk("R6 txc", {7'd0, flag_txc}, 8'd0);
        chk("R6 ovr", {7'd0, flag_ovr}, 8'd0);
        chk("R6 tx_valid", {7'd0, tx_valid}, 8'd0);
        chk("R6 rdata", bus_rdata, 8'd0);

        // Vector table: R1, R3, R7, R10
        for (int i = 0; i < NVEC; i++) begin
            char_sel = VEC[i][33:32];
            bus_write(VEC[i][31:24]);
            chk("R10 tx mask", tx_data, VEC[i][23:16]);
            chk("R1 dre low", {7'd0, flag_dre}, 8'd0);
            chk("R1 valid", {7'd0, tx_valid}, 8'd1);
            handoff();
            chk("R3 dre high", {7'd0, flag_dre}, 8'd1);
            push_rx(VEC[i][15:8]);
            chk("R7 rxc", {7'd0, flag_rxc}, 8'd1);
            chk("R10 rx mask", bus_rdata, VEC[i][7:0]);
            bus_read();
            chk("R7 empty after read", {7'd0, flag_rxc}, 8'd0);
        end

        char_sel = 2'd3;

        // R2: write while full is dropped
        bus_write(8'h5C);
        bus_write(8'hC3);
        chk("R2 data kept", tx_data, 8'h5C);
        chk("R2 dre", {7'd0, flag_dre}, 8'd0);

        // R3: disabled transmitter holds
        tx_en = 0;
        @(negedge clk);
        chk("R3 valid off", {7'd0, tx_valid}, 8'd0);
        handoff();
        chk("R3 still full", {7'd0, flag_dre}, 8'd0);
        tx_en = 1;
        handoff();
        chk("R3 emptied", {7'd0, flag_dre}, 8'd1);

        // R4 / R5
        tx_frame_done = 1; step();
        chk("R4 set", {7'd0, flag_txc}, 8'd1);
        txc_ack = 1; step();
        chk("R5 ack clears", {7'd0, flag_txc}, 8'd0);
        tx_frame_done = 1; step();
        txc_clr = 1; step();
        chk("R5 clr clears", {7'd0, flag_txc}, 8'd0);
        tx_frame_done = 1; step();
        txc_clr = 1; tx_frame_done = 1; step();
        chk("R5 set wins", {7'd0, flag_txc}, 8'd1);
        txc_clr = 1; step();
        bus_write(8'h44);
        tx_frame_done = 1; step();
        chk("R4 no set while held", {7'd0, flag_txc}, 8'd0);
        handoff();

        // R7 ordering
        push_rx(8'h11);
        push_rx(8'h22);
        chk("R7 head first", bus_rdata, 8'h11);
        bus_read();
        chk("R7 head second", bus_rdata, 8'h22);
        bus_read();
        chk("R7 drained", {7'd0, flag_rxc}, 8'd0);

        // R8 overrun
        push_rx(8'h01);
        push_rx(8'h02);
        push_rx(8'h03);
        chk("R8 ovr set", {7'd0, flag_ovr}, 8'd1);
        chk("R8 head kept", bus_rdata, 8'h01);
        bus_read();
        chk("R8 ovr cleared", {7'd0, flag_ovr}, 8'd0);
        chk("R8 second kept", bus_rdata, 8'h02);
        bus_read();
        chk("R8 third dropped", {7'd0, flag_rxc}, 8'd0);
        push_rx(8'h04);
        push_rx(8'h05);
        rx_byte = 8'h06; rx_strobe = 1; bus_rd = 1; step();
        chk("R8 coincident no ovr", {7'd0, flag_ovr}, 8'd0);
        chk("R8 coincident head", bus_rdata, 8'h05);
        bus_read();
        chk("R8 coincident accepted", bus_rdata, 8'h06);
        bus_read();

        // R9 flush
        push_rx(8'h07);
        push_rx(8'h08);
        push_rx(8'h09);
        rx_en = 0; step();
        chk("R9 rxc flushed", {7'd0, flag_rxc}, 8'd0);
        chk("R9 ovr flushed", {7'd0, flag_ovr}, 8'd0);
        push_rx(8'h0A);
        rx_en = 1; step();
        chk("R9 strobe ignored", {7'd0, flag_rxc}, 8'd0);

        // R11 empty read
        bus_rd = 1;
        @(negedge clk);
        chk("R11 rdata zero", bus_rdata, 8'd0);
        step();
        chk("R11 rxc", {7'd0, flag_rxc}, 8'd0);
        chk("R11 ovr", {7'd0, flag_ovr}, 8'd0);
        push_rx(8'h3B);
        chk("R11 queue intact", bus_rdata, 8'h3B);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule